// File: doc/BRIEF.md
# Multi-Master Shared Bus Arbiter

This block lets one processor share a system bus with other masters. It watches the processor's 3-bit cycle status code and decides when the processor needs the shared bus. Four strap-selected modes control that decision. The shared-bus handshake runs on its own bus clock and consists of:

- an active-low request out;
- an active-low priority in;
- a priority out for a daisy chain;
- an "occupied" line and a "shared request" line, both open-drain. Each is modelled as a sensed input plus a pull-enable output.

While the processor does not own the bus, an active-low drive-enable keeps the processor's local drivers off the bus.

Once the arbiter holds the bus, it keeps it until something forces it off. It can let go only when the current status code no longer needs the bus. At that point it releases if any of these holds:

- the processor is halted;
- a higher-priority master has taken priority away;
- another master is asserting the shared request line.

A processor lock input blocks every release. A second lock input blocks only releases caused by the shared request line, unless a strap makes such requests count as higher priority. The processor clock and the bus clock are independent. Decisions cross between them through flop synchronisers.

Top module: `barb_top`

## Requirements
- R1: Status codes are decoded as 3'b111 idle, 3'b011 halt, 3'b000/001/010 I/O class and 3'b100/101/110 memory class. With io_split_n=1 and res_split=0, any code other than idle or halt needs the bus. A status presented before cpu_clk edge k takes effect on the third falling bus_clk edge after it.
- R2: With io_split_n=0 and res_split=0, only memory-class codes need the bus.
- R3: With io_split_n=1 and res_split=1, a non-idle, non-halt code needs the bus only while map_sys is 1.
- R4: With io_split_n=0 and res_split=1, only a memory-class code with map_sys at 1 needs the bus.
- R5: An idle arbiter that needs the bus drives req_out_n low. It takes the bus at a falling bus_clk edge where occ_in_n is 1 and pri_in_n is 0, and from then asserts occ_pull.
- R6: An owner releases only when the current status does not need the bus. It then releases at a falling bus_clk edge if halt status is present, pri_in_n is 1, or share_req_in_n is 0. On release, req_out_n goes high and occ_pull goes low.
- R7: While hold_n is 0, no release of any kind occurs.
- R8: With yield_any at 0, common_hold_n at 0 blocks releases caused only by share_req_in_n. With yield_any at 1, a shared request releases the bus like a loss of priority, and only hold_n blocks it.
- R9: share_req_pull is 1 exactly while the arbiter requests the bus without owning it.
- R10: pri_out_n equals pri_in_n while the arbiter is not requesting, and is 1 while it requests or owns the bus.
- R11: After rst_n, or at a falling bus_clk edge with sys_clear_n at 0, the arbiter neither requests nor owns the bus.
- R12: drv_en_n goes low at the bus_clk edge where ownership is gained. It returns high only once loss of ownership has passed two cpu_clk edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cpu_clk | input | 1 | Processor clock |
| bus_clk | input | 1 | Shared-bus clock; the arbiter acts on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_clear_n | input | 1 | Shared-bus clear, active low |
| cpu_stat | input | 3 | Processor cycle status code |
| map_sys | input | 1 | Address-map select: 1 = shared bus, 0 = resident bus |
| hold_n | input | 1 | Processor lock, active low |
| common_hold_n | input | 1 | Blocks shared-request releases, active low |
| io_split_n | input | 1 | Strap: 0 = only memory cycles use the shared bus |
| res_split | input | 1 | Strap: 1 = map_sys gates requests |
| yield_any | input | 1 | Strap: 1 = shared request acts as higher priority |
| pri_in_n | input | 1 | Priority granted, active low |
| occ_in_n | input | 1 | Sensed occupied line, 0 = bus in use |
| share_req_in_n | input | 1 | Sensed shared request line, active low |
| req_out_n | output | 1 | Bus request, active low |
| pri_out_n | output | 1 | Daisy-chain priority out, active low |
| occ_pull | output | 1 | Pull the occupied line low |
| share_req_pull | output | 1 | Pull the shared request line low |
| drv_en_n | output | 1 | Local bus driver enable, active low |

## Verification
Each of the four strap modes is driven with I/O-class, memory-class, halt and idle codes, combined with both map_sys levels. This separates which class each mode treats as needing the bus. Release is tried with every trigger (halt, priority loss, shared request) in two situations: during a cycle that still needs the bus, and after it ends. This shows that triggers are deferred, not dropped. The two lock inputs are combined with both yield_any levels to tell apart blanket blocking from blocking of shared requests only. A busy bus, a bus without priority and a clear during ownership show the waiting state, the daisy-chain pass-through and the clear path.

// File: rtl/barb_pkg.sv
package barb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE = 2'd0,
    ARB_WAIT = 2'd1,
    ARB_OWN  = 2'd2
  } arb_state_e;

  localparam int          STAT_W  = 3;
  localparam logic [2:0]  ST_IDLE = 3'b111;
  localparam logic [2:0]  ST_HALT = 3'b011;
endpackage

// File: rtl/barb_sync.sv
// Multi-stage flop synchroniser; with d tied high it doubles as a reset
// synchroniser (asynchronous assert, synchronous release).
module barb_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/barb_status_dec.sv
// Processor-clock side: turns the status code and straps into
// "needs bus", "halted" and "locked" flags, registered once.
module barb_status_dec
  import barb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] cpu_stat,
  input  logic              map_sys,
  input  logic              hold_n,
  input  logic              io_split_n,
  input  logic              res_split,
  output logic              need_q,
  output logic              halt_q,
  output logic              locked_q
);
  logic is_idle, is_halt, is_active, is_mem;
  logic cls_ok, map_ok, need_d;

  always_comb begin
    is_idle   = (cpu_stat == ST_IDLE);
    is_halt   = (cpu_stat == ST_HALT);
    is_active = !is_idle && !is_halt;
    is_mem    = cpu_stat[STAT_W-1] && !is_idle;
    cls_ok    = io_split_n ? is_active : is_mem;
    map_ok    = res_split ? map_sys : 1'b1;
    need_d    = cls_ok && map_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      need_q   <= 1'b0;
      halt_q   <= 1'b0;
      locked_q <= 1'b0;
    end else begin
      need_q   <= need_d;
      halt_q   <= is_halt;
      locked_q <= !hold_n;
    end
  end
endmodule

// File: rtl/barb_bus_fsm.sv
// Bus-clock side: idle / waiting / owning, with the release rules.
module barb_bus_fsm
  import barb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sys_clear_n,
  input  logic need_s,
  input  logic halt_s,
  input  logic locked_s,
  input  logic pri_in_n,
  input  logic occ_in_n,
  input  logic share_req_in_n,
  input  logic common_hold_n,
  input  logic yield_any,
  output logic own_o,
  output logic wait_o
);
  arb_state_e st_q, st_d;
  logic share_hit, rel_ok, grab_ok;

  always_comb begin
    share_hit = !share_req_in_n && (yield_any || common_hold_n);
    rel_ok    = !need_s && !locked_s && (halt_s || pri_in_n || share_hit);
    grab_ok   = occ_in_n && !pri_in_n;
    st_d      = st_q;
    unique case (st_q)
      ARB_IDLE: if (need_s) st_d = ARB_WAIT;
      ARB_WAIT: begin
        if (!need_s)      st_d = ARB_IDLE;
        else if (grab_ok) st_d = ARB_OWN;
      end
      ARB_OWN:  if (rel_ok) st_d = ARB_IDLE;
      default:  st_d = ARB_IDLE;
    endcase
    if (!sys_clear_n) st_d = ARB_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ARB_IDLE;
    else        st_q <= st_d;
  end

  assign own_o  = (st_q == ARB_OWN);
  assign wait_o = (st_q == ARB_WAIT);
endmodule

// File: rtl/barb_top.sv
module barb_top
  import barb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              cpu_clk,
  input  logic              bus_clk,
  input  logic              rst_n,
  input  logic              sys_clear_n,
  input  logic [STAT_W-1:0] cpu_stat,
  input  logic              map_sys,
  input  logic              hold_n,
  input  logic              common_hold_n,
  input  logic              io_split_n,
  input  logic              res_split,
  input  logic              yield_any,
  input  logic              pri_in_n,
  input  logic              occ_in_n,
  input  logic              share_req_in_n,
  output logic              req_out_n,
  output logic              pri_out_n,
  output logic              occ_pull,
  output logic              share_req_pull,
  output logic              drv_en_n
);
  localparam int XW = 3;

  logic bus_clk_n;
  logic cpu_rst_n, bus_rst_n;
  logic need_c, halt_c, locked_c;
  logic [XW-1:0] x_s;
  logic own_b, wait_b, own_c;

  assign bus_clk_n = ~bus_clk;

  barb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_cpu_rst (
    .clk(cpu_clk), .rst_n(rst_n), .d(1'b1), .q(cpu_rst_n));
  barb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_bus_rst (
    .clk(bus_clk_n), .rst_n(rst_n), .d(1'b1), .q(bus_rst_n));

  barb_status_dec u_dec (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .cpu_stat(cpu_stat),
    .map_sys(map_sys), .hold_n(hold_n), .io_split_n(io_split_n),
    .res_split(res_split), .need_q(need_c), .halt_q(halt_c),
    .locked_q(locked_c));

  barb_sync #(.WIDTH(XW), .STAGES(SYNC_STAGES)) u_to_bus (
    .clk(bus_clk_n), .rst_n(bus_rst_n),
    .d({need_c, halt_c, locked_c}), .q(x_s));

  barb_bus_fsm u_fsm (
    .clk(bus_clk_n), .rst_n(bus_rst_n), .sys_clear_n(sys_clear_n),
    .need_s(x_s[2]), .halt_s(x_s[1]), .locked_s(x_s[0]),
    .pri_in_n(pri_in_n), .occ_in_n(occ_in_n),
    .share_req_in_n(share_req_in_n), .common_hold_n(common_hold_n),
    .yield_any(yield_any), .own_o(own_b), .wait_o(wait_b));

  barb_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_to_cpu (
    .clk(cpu_clk), .rst_n(cpu_rst_n), .d(own_b), .q(own_c));

  assign req_out_n      = !(own_b || wait_b);
  assign occ_pull       = own_b;
  assign share_req_pull = wait_b;
  assign pri_out_n      = pri_in_n || !req_out_n;
  // gain is seen at once from the bus side; loss waits for the cpu side
  assign drv_en_n       = !(own_b || own_c);
endmodule

// File: rtl/barb_chk.sv
module barb_chk (
  input logic bus_clk,
  input logic rst_n,
  input logic sys_clear_n,
  input logic req_out_n,
  input logic occ_pull,
  input logic share_req_pull,
  input logic pri_out_n,
  input logic drv_en_n
);
  // R5
  occ_needs_req_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    occ_pull |-> !req_out_n);
  // R9
  share_excl_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    share_req_pull |-> (!occ_pull && !req_out_n));
  // R10
  pri_block_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !req_out_n |-> pri_out_n);
  // R11
  clear_drop_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    !sys_clear_n |=> (req_out_n && !occ_pull));
  // R12
  drv_own_chk: assert property (@(negedge bus_clk) disable iff (!rst_n)
    occ_pull |-> !drv_en_n);
endmodule

bind barb_top barb_chk u_chk (
  .bus_clk(bus_clk), .rst_n(rst_n), .sys_clear_n(sys_clear_n),
  .req_out_n(req_out_n), .occ_pull(occ_pull),
  .share_req_pull(share_req_pull), .pri_out_n(pri_out_n),
  .drv_en_n(drv_en_n));

// File: tb/tb_barb_top.sv
module tb_barb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz; both clock ports share it

  logic       rst_n, sys_clear_n, map_sys, hold_n, common_hold_n;
  logic       io_split_n, res_split, yield_any, pri_in_n, occ_in_n, share_req_in_n;
  logic [2:0] cpu_stat;
  logic       req_out_n, pri_out_n, occ_pull, share_req_pull, drv_en_n;

  barb_top dut (
    .cpu_clk(clk), .bus_clk(clk), .rst_n(rst_n), .sys_clear_n(sys_clear_n),
    .cpu_stat(cpu_stat), .map_sys(map_sys), .hold_n(hold_n),
    .common_hold_n(common_hold_n), .io_split_n(io_split_n),
    .res_split(res_split), .yield_any(yield_any), .pri_in_n(pri_in_n),
    .occ_in_n(occ_in_n), .share_req_in_n(share_req_in_n),
    .req_out_n(req_out_n), .pri_out_n(pri_out_n), .occ_pull(occ_pull),
    .share_req_pull(share_req_pull), .drv_en_n(drv_en_n));

  // planned values, applied just after a rising edge
  logic [2:0] v_stat = 3'b111;
  bit v_rst = 0, v_clr = 1, v_map = 0, v_hold = 1, v_chold = 1;
  bit v_ion = 1, v_res = 0, v_yield = 0, v_pri = 0, v_occ = 1, v_share = 1;

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_tag = "R11";

  // reference model
  bit need_h[$], halt_h[$], lock_h[$], own_h[$];
  int mst = 0;   // 0 idle, 1 waiting, 2 owning

  function automatic bit wants(logic [2:0] s, bit m, bit ion, bit rs);
    bit act, mem, cls;
    act = !(s == 3'b111 || s == 3'b011);
    mem = (s >= 3'b100) && (s != 3'b111);
    cls = ion ? act : mem;
    return cls && (rs ? m : 1'b1);
  endfunction

  task automatic chk(string nm, string rq, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s [%s] actual=%b expected=%b at %0t",
               rq, nm, cur_tag, act, exp, $time);
    end
  endtask

  task automatic step();
    bit n, h, lk, rel, sh, own_now, own_old;
    @(posedge clk);
    #1;
    rst_n = v_rst; sys_clear_n = v_clr; cpu_stat = v_stat; map_sys = v_map;
    hold_n = v_hold; common_hold_n = v_chold; io_split_n = v_ion;
    res_split = v_res; yield_any = v_yield; pri_in_n = v_pri;
    occ_in_n = v_occ; share_req_in_n = v_share;
    // cpu-side inputs reach the bus decision three falling edges later
    need_h.push_back(v_rst && wants(v_stat, v_map, v_ion, v_res));
    halt_h.push_back(v_rst && v_stat == 3'b011);
    lock_h.push_back(v_rst && !v_hold);
    n  = need_h[need_h.size()-4];
    h  = halt_h[halt_h.size()-4];
    lk = lock_h[lock_h.size()-4];
    if (!v_rst || !v_clr) mst = 0;
    else begin
      case (mst)
        0: if (n) mst = 1;
        1: if (!n) mst = 0; else if (v_occ && !v_pri) mst = 2;
        default: begin
          sh  = !v_share && (v_yield || v_chold);
          rel = !n && !lk && (h || v_pri || sh);
          if (rel) mst = 0;
        end
      endcase
    end
    own_now = (mst == 2);
    own_h.push_back(own_now);
    own_old = own_h[own_h.size()-3];
    #6;
    chk("req_out_n", "R5", req_out_n, mst == 0);
    chk("occ_pull", "R5", occ_pull, own_now);
    chk("share_req_pull", "R9", share_req_pull, mst == 1);
    chk("pri_out_n", "R10", pri_out_n, v_pri || (mst != 0));
    chk("drv_en_n", "R12", drv_en_n, !(own_now || own_old));
  endtask

  task automatic go(int n);
    repeat (n) step();
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (3) need_h.push_back(0);
    repeat (3) halt_h.push_back(0);
    repeat (3) lock_h.push_back(0);
    repeat (2) own_h.push_back(0);
    rst_n = 0; sys_clear_n = 1; cpu_stat = 3'b111; map_sys = 0; hold_n = 1;
    common_hold_n = 1; io_split_n = 1; res_split = 0; yield_any = 0;
    pri_in_n = 0; occ_in_n = 1; share_req_in_n = 1;

    // R11 reset state
    cur_tag = "R11"; go(3);
    v_rst = 1; go(6);

    // R1 single-bus mode: I/O code requests and is granted, held while idle
    cur_tag = "R1";
    v_stat = 3'b000; go(6);
    v_stat = 3'b111; go(4);
    v_stat = 3'b101; go(2);
    v_stat = 3'b111; go(2);
    // R6 priority loss while idle releases
    cur_tag = "R6";
    v_pri = 1; go(4); v_pri = 0; go(1);
    // R1 halt does not request
    cur_tag = "R1";
    v_stat = 3'b011; go(5);
    v_stat = 3'b110; go(6);
    // R6 priority loss during a needing cycle is deferred
    cur_tag = "R6";
    v_pri = 1; go(4);
    v_stat = 3'b111; go(4);
    v_pri = 0; go(1);

    // R2 IOB-only style: I/O ignored, memory requests
    cur_tag = "R2";
    v_ion = 0; v_res = 0;
    v_stat = 3'b001; go(5);
    v_stat = 3'b100; go(6);
    v_stat = 3'b010; go(3);
    cur_tag = "R6";
    v_share = 0; go(4); v_share = 1; go(1);

    // R3 map-gated mode
    cur_tag = "R3";
    v_ion = 1; v_res = 1;
    v_stat = 3'b001; v_map = 0; go(5);
    v_map = 1; go(6);
    v_map = 0; go(3);

    // R7 lock blocks priority loss and halt
    cur_tag = "R7";
    v_hold = 0; go(4);
    v_pri = 1; go(4);
    v_stat = 3'b011; go(4);
    v_hold = 1; go(5);
    v_pri = 0; v_stat = 3'b111; go(2);

    // R4 memory and map both required
    cur_tag = "R4";
    v_ion = 0; v_res = 1;
    v_stat = 3'b110; v_map = 0; go(5);
    v_stat = 3'b001; v_map = 1; go(5);
    v_stat = 3'b110; v_map = 1; go(6);
    v_stat = 3'b111; v_map = 0; go(3);
    // R8 common hold blocks shared request unless yield_any
    cur_tag = "R8";
    v_chold = 0; v_share = 0; go(5);
    v_yield = 1; go(4);
    v_yield = 0; v_chold = 1; v_share = 1; go(2);

    // R5 / R9 / R10 waiting on a busy bus and on missing priority
    cur_tag = "R5";
    v_ion = 1; v_res = 0;
    v_stat = 3'b000; v_occ = 0; go(6);
    cur_tag = "R9";
    v_occ = 1; v_pri = 1; go(3);
    cur_tag = "R10";
    v_pri = 0; go(3);
    // R11 clear while owning, then re-acquire
    cur_tag = "R11";
    v_clr = 0; go(2);
    v_clr = 1; go(5);
    // R10 pass-through after release
    cur_tag = "R10";
    v_stat = 3'b111; go(2);
    v_pri = 1; go(4);
    v_pri = 0; go(2); v_pri = 1; go(1); v_pri = 0; go(2);
    // R6 shared request in single-bus mode; R12 drive-enable on both edges
    cur_tag = "R12";
    v_stat = 3'b100; go(6);
    v_stat = 3'b111; go(2);
    v_share = 0; go(4); v_share = 1; go(3);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule